// File: doc/BRIEF.md
# DRAM Low-Power Entry Controller

This block decides when a DDR SDRAM controller puts its memory into a low-power state and when it brings it back. A 2-bit mode input picks the target state. The choices are none, self refresh, power-down and deep power-down. A 2-bit idle-time input sets how many idle cycles must follow the last transfer before entry. The block watches a transfer-busy input and an access-request input. It emits single-cycle command strobes for each kind of entry and for exit, and it drives the memory CKE and the memory clock enable.

In self refresh and power-down the block re-enters the state after every access. An access that arrives while the memory sleeps first triggers an exit. The exit raises CKE and then holds `acc_ready` low for a short fixed settle time, which is the point at which the access may go ahead. Deep power-down is one-way: any access made in that state only raises an error flag. Two overrides act outside the mode field. A clock-freeze input gates the memory clock. A power-off input forces CKE low.

Top module: `dram_lp_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, the block is awake: `cke`=1, `acc_ready`=1, `mem_clk_en`=1 (with `clk_freeze`=0), `dpd_err`=0, and no strobe is high.
- R2: `mode_sel` encodes 0 = stay awake, 1 = self refresh, 2 = power-down, 3 = deep power-down. With 0 the block never issues an entry strobe and `cke` stays 1.
- R3: `idle_sel` encodes 0 = enter on the first idle clock edge after activity, 1 = enter after 64 full idle cycles, 2 = after 128, and 3 = the same as 0. A cycle is idle when `xfer_busy`=0 and `acc_req`=0. Any busy or request cycle restarts the count. A request that arrives on the edge where the count would expire prevents the entry.
- R4: Self-refresh entry pulses `cmd_sr_enter` for one cycle. From that cycle onward `cke`=0, `mem_clk_en`=0 and `acc_ready`=0.
- R5: Power-down entry pulses `cmd_pd_enter` for one cycle. From that cycle onward `cke`=0 while `mem_clk_en` stays 1.
- R6: In self refresh or power-down, `acc_req`=1 causes `cmd_exit` to pulse on the next edge, with `cke`=1 from that cycle on. `acc_ready` then stays 0 for 2 cycles when `slow_exit`=0, or 6 cycles when `slow_exit`=1, including the strobe cycle, and then goes to 1. Once the request drops, the state is entered again under R3.
- R7: Deep power-down entry pulses `cmd_dpd_enter` once, with `cke`=0 and `mem_clk_en`=0. An access in that state issues no exit strobe, leaves `cke` at 0 and sets `dpd_err`, which stays set until reset.
- R8: `clk_freeze`=1 forces `mem_clk_en` to 0 in the same cycle, in any state.
- R9: `power_off`=1 makes `cke`=0 and `acc_ready`=0 from the next edge, whatever `mode_sel` holds. When it drops, the R6 exit sequence runs.
- R10: Setting `mode_sel` to 0 while in self refresh or power-down runs the R6 exit sequence.
- R11: At most one strobe is high in any cycle, and every expected strobe appears exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Low-power target state |
| idle_sel | input | 2 | Idle time before entry |
| slow_exit | input | 1 | Selects the long exit settle time |
| clk_freeze | input | 1 | Gates the memory clock |
| power_off | input | 1 | Power-off override |
| xfer_busy | input | 1 | A transfer is in progress |
| acc_req | input | 1 | An access is waiting |
| acc_ready | output | 1 | Access may proceed |
| cke | output | 1 | Memory clock-enable pin level |
| mem_clk_en | output | 1 | Memory clock gate |
| cmd_sr_enter | output | 1 | Self-refresh entry strobe |
| cmd_pd_enter | output | 1 | Power-down entry strobe |
| cmd_dpd_enter | output | 1 | Deep power-down entry strobe |
| cmd_exit | output | 1 | Low-power exit strobe |
| dpd_err | output | 1 | Access attempted during deep power-down |

## Verification
The idle timer expiring and a new access request can fall on the same clock edge. The bench provokes this by dropping the request, waiting exactly 64 idle cycles with `idle_sel`=1, and raising `acc_req` in the last of those cycles. The scoreboard holds no expected entry strobe for that edge, so any entry strobe there is reported. The bench also checks that `cke` and `acc_ready` stay high. Once the request drops, it expects an entry exactly 65 edges later.

// File: rtl/dram_lp_ctrl.sv
module dram_lp_ctrl #(
  parameter int IDLE_SHORT = 64,
  parameter int IDLE_LONG  = 128,
  parameter int EXIT_FAST  = 2,
  parameter int EXIT_SLOW  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic [1:0] idle_sel,
  input  logic       slow_exit,
  input  logic       clk_freeze,
  input  logic       power_off,
  input  logic       xfer_busy,
  input  logic       acc_req,
  output logic       acc_ready,
  output logic       cke,
  output logic       mem_clk_en,
  output logic       cmd_sr_enter,
  output logic       cmd_pd_enter,
  output logic       cmd_dpd_enter,
  output logic       cmd_exit,
  output logic       dpd_err
);
  localparam int IW = $clog2(IDLE_LONG + 1);
  localparam int EW = $clog2(EXIT_SLOW + 1);

  typedef enum logic [2:0] {S_ACT, S_SR, S_PD, S_DPD, S_EXIT, S_OFF} st_t;

  st_t           st;
  logic [IW-1:0] idle_cnt;
  logic [IW-1:0] idle_lim;
  logic [EW-1:0] ex_cnt;
  logic [EW-1:0] ex_len;
  logic          idle;
  logic          due;

  always_comb begin
    case (idle_sel)
      2'd1:    idle_lim = IW'(IDLE_SHORT);
      2'd2:    idle_lim = IW'(IDLE_LONG);
      default: idle_lim = '0;
    endcase
  end

  assign idle   = !xfer_busy && !acc_req;
  assign due    = idle && (mode_sel != 2'd0) && (idle_cnt >= idle_lim);
  assign ex_len = slow_exit ? EW'(EXIT_SLOW - 1) : EW'(EXIT_FAST - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_ACT;
      idle_cnt      <= '0;
      ex_cnt        <= '0;
      cmd_sr_enter  <= 1'b0;
      cmd_pd_enter  <= 1'b0;
      cmd_dpd_enter <= 1'b0;
      cmd_exit      <= 1'b0;
      dpd_err       <= 1'b0;
    end else begin
      cmd_sr_enter  <= 1'b0;
      cmd_pd_enter  <= 1'b0;
      cmd_dpd_enter <= 1'b0;
      cmd_exit      <= 1'b0;
      if (power_off && st != S_OFF) begin
        st       <= S_OFF;
        idle_cnt <= '0;
      end else begin
        case (st)
          S_ACT: begin
            if (due) begin
              idle_cnt <= '0;
              case (mode_sel)
                2'd1:    begin st <= S_SR;  cmd_sr_enter  <= 1'b1; end
                2'd2:    begin st <= S_PD;  cmd_pd_enter  <= 1'b1; end
                default: begin st <= S_DPD; cmd_dpd_enter <= 1'b1; end
              endcase
            end else if (!idle) begin
              idle_cnt <= '0;
            end else if (idle_cnt != '1) begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
          S_SR, S_PD: begin
            if (acc_req || mode_sel == 2'd0) begin
              st       <= S_EXIT;
              cmd_exit <= 1'b1;
              ex_cnt   <= ex_len;
            end
          end
          S_DPD: begin
            if (acc_req) dpd_err <= 1'b1;
          end
          S_EXIT: begin
            if (ex_cnt == '0) st <= S_ACT;
            else ex_cnt <= ex_cnt - 1'b1;
          end
          S_OFF: begin
            if (!power_off) begin
              st       <= S_EXIT;
              cmd_exit <= 1'b1;
              ex_cnt   <= ex_len;
            end
          end
          default: st <= S_ACT;
        endcase
      end
    end
  end

  assign cke        = (st == S_ACT) || (st == S_EXIT);
  assign acc_ready  = (st == S_ACT);
  assign mem_clk_en = !clk_freeze && (st != S_SR) && (st != S_DPD);
endmodule

// File: rtl/dram_lp_ctrl_chk.sv
module dram_lp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       clk_freeze,
  input logic       power_off,
  input logic       acc_ready,
  input logic       cke,
  input logic       mem_clk_en,
  input logic       cmd_sr_enter,
  input logic       cmd_pd_enter,
  input logic       cmd_dpd_enter,
  input logic       cmd_exit,
  input logic       dpd_err
);
  // R1
  ready_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> cke);
  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd0 && acc_ready) |=> !(cmd_sr_enter || cmd_pd_enter || cmd_dpd_enter));
  // R4
  sr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sr_enter |-> (!cke && !mem_clk_en && !acc_ready));
  // R5
  pd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pd_enter |-> (!cke && (mem_clk_en == !clk_freeze)));
  // R6
  exit_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_exit |-> (cke && !acc_ready));
  // R7
  dpd_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_err |=> dpd_err);
  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_freeze |-> !mem_clk_en);
  // R9
  power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_off |=> (!cke && !acc_ready));
  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_sr_enter, cmd_pd_enter, cmd_dpd_enter, cmd_exit}));
  // R11
  exit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_exit |=> !cmd_exit);
endmodule

bind dram_lp_ctrl dram_lp_ctrl_chk u_dram_lp_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .clk_freeze(clk_freeze),
  .power_off(power_off), .acc_ready(acc_ready), .cke(cke), .mem_clk_en(mem_clk_en),
  .cmd_sr_enter(cmd_sr_enter), .cmd_pd_enter(cmd_pd_enter),
  .cmd_dpd_enter(cmd_dpd_enter), .cmd_exit(cmd_exit), .dpd_err(dpd_err)
);

// File: tb/dram_lp_ctrl_bench.sv
`timescale 1ns/1ps
module dram_lp_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [1:0] idle_sel = 2'd0;
  logic       slow_exit = 1'b0;
  logic       clk_freeze = 1'b0;
  logic       power_off = 1'b0;
  logic       xfer_busy = 1'b0;
  logic       acc_req = 1'b0;
  logic       acc_ready, cke, mem_clk_en;
  logic       cmd_sr_enter, cmd_pd_enter, cmd_dpd_enter, cmd_exit, dpd_err;

  dram_lp_ctrl u_dram_lp_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .idle_sel(idle_sel),
    .slow_exit(slow_exit), .clk_freeze(clk_freeze), .power_off(power_off),
    .xfer_busy(xfer_busy), .acc_req(acc_req), .acc_ready(acc_ready), .cke(cke),
    .mem_clk_en(mem_clk_en), .cmd_sr_enter(cmd_sr_enter), .cmd_pd_enter(cmd_pd_enter),
    .cmd_dpd_enter(cmd_dpd_enter), .cmd_exit(cmd_exit), .dpd_err(dpd_err)
  );

  always #2 clk = ~clk;

  typedef struct {
    string tag;
    int    code;
    int    due;
  } ev_t;

  ev_t q[$];
  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  int  mcode;
  int  mcnt;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_ev(string tag, int code, int due);
    ev_t e;
    e.tag = tag; e.code = code; e.due = due;
    q.push_back(e);
  endtask

  // strobe codes: 1 self refresh, 2 power-down, 3 deep power-down, 4 exit
  always @(negedge clk) begin
    if (rst_n && !done) begin
      mcnt  = int'(cmd_sr_enter) + int'(cmd_pd_enter) + int'(cmd_dpd_enter) + int'(cmd_exit);
      mcode = cmd_sr_enter ? 1 : cmd_pd_enter ? 2 : cmd_dpd_enter ? 3 : cmd_exit ? 4 : 0;
      if (mcnt > 1) begin
        checks++; errors++;
        $display("FAIL R11: actual %0d strobes expected at most 1", mcnt);
      end
      if (q.size() > 0 && q[0].due == cyc) begin
        checks++;
        if (mcode != q[0].code) begin
          errors++;
          $display("FAIL %s: actual strobe %0d expected %0d at cycle %0d", q[0].tag, mcode, q[0].code, cyc);
        end
        void'(q.pop_front());
      end else if (mcode != 0) begin
        checks++; errors++;
        $display("FAIL R11: actual strobe %0d expected 0 at cycle %0d", mcode, cyc);
      end
    end
  end

  task automatic burst_and_idle(string tag, int code, int lim);
    xfer_busy = 1'b1;
    step(1);
    xfer_busy = 1'b0;
    expect_ev(tag, code, cyc + 1 + lim);
  endtask

  task automatic wake(string tag, int d);
    acc_req = 1'b1;
    expect_ev(tag, 4, cyc + 1);
    step(1);
    chk(tag, cke, 1);
    chk(tag, acc_ready, 0);
    step(d - 1);
    chk(tag, acc_ready, 0);
    step(1);
    chk(tag, acc_ready, 1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual hang expected finish");
    finish_run();
  end

  initial begin
    step(3);
    chk("R1", cke, 1);
    chk("R1", acc_ready, 1);
    rst_n = 1'b1;
    step(1);
    chk("R1", cke, 1);
    chk("R1", acc_ready, 1);
    chk("R1", mem_clk_en, 1);
    chk("R1", dpd_err, 0);

    // R2: mode 0 never enters
    xfer_busy = 1'b1; step(1); xfer_busy = 1'b0;
    step(20);
    chk("R2", cke, 1);

    // R4: self refresh, immediate entry
    mode_sel = 2'd1;
    burst_and_idle("R4", 1, 0);
    step(1);
    chk("R4", cke, 0);
    chk("R4", mem_clk_en, 0);
    chk("R4", acc_ready, 0);

    // R6: fast exit then re-entry
    wake("R6", 2);
    acc_req = 1'b0;
    expect_ev("R6", 1, cyc + 1);
    step(2);
    chk("R6", cke, 0);

    // R10: mode to 0 wakes
    mode_sel = 2'd0;
    expect_ev("R10", 4, cyc + 1);
    step(1);
    chk("R10", cke, 1);
    step(2);
    chk("R10", acc_ready, 1);
    step(10);
    chk("R10", cke, 1);

    // R5: power-down, slow exit
    mode_sel = 2'd2;
    slow_exit = 1'b1;
    burst_and_idle("R5", 2, 0);
    step(1);
    chk("R5", cke, 0);
    chk("R5", mem_clk_en, 1);

    // R8: clock freeze
    clk_freeze = 1'b1;
    #1;
    chk("R8", mem_clk_en, 0);
    step(1);
    clk_freeze = 1'b0;
    #1;
    chk("R8", mem_clk_en, 1);
    step(1);

    // R3: 64-cycle idle time
    wake("R6", 6);
    idle_sel = 2'd1;
    acc_req = 1'b0;
    expect_ev("R3", 2, cyc + 65);
    step(65);
    chk("R3", cke, 0);

    // R3: busy restarts the count
    wake("R3", 6);
    acc_req = 1'b0;
    step(30);
    xfer_busy = 1'b1; step(1); xfer_busy = 1'b0;
    expect_ev("R3", 2, cyc + 65);
    step(65);
    chk("R3", cke, 0);

    // R3: 128-cycle idle time
    wake("R3", 6);
    idle_sel = 2'd2;
    acc_req = 1'b0;
    expect_ev("R3", 2, cyc + 129);
    step(129);
    chk("R3", cke, 0);

    // R3: request on the expiry edge blocks entry
    wake("R3", 6);
    idle_sel = 2'd1;
    acc_req = 1'b0;
    step(64);
    acc_req = 1'b1;
    step(1);
    chk("R3", cke, 1);
    chk("R3", acc_ready, 1);
    step(3);
    acc_req = 1'b0;
    expect_ev("R3", 2, cyc + 65);
    step(65);
    chk("R3", cke, 0);

    // R3: encoding 3 acts as 0
    wake("R3", 6);
    idle_sel = 2'd3;
    acc_req = 1'b0;
    expect_ev("R3", 2, cyc + 1);
    step(1);
    chk("R3", cke, 0);

    // R9: power-off override
    mode_sel = 2'd0;
    expect_ev("R10", 4, cyc + 1);
    step(7);
    chk("R10", acc_ready, 1);
    power_off = 1'b1;
    step(1);
    chk("R9", cke, 0);
    chk("R9", acc_ready, 0);
    step(5);
    chk("R9", cke, 0);
    power_off = 1'b0;
    expect_ev("R9", 4, cyc + 1);
    step(1);
    chk("R9", cke, 1);
    step(6);
    chk("R9", acc_ready, 1);

    // R7: deep power-down
    mode_sel = 2'd3;
    idle_sel = 2'd0;
    burst_and_idle("R7", 3, 0);
    step(1);
    chk("R7", cke, 0);
    chk("R7", mem_clk_en, 0);
    chk("R7", dpd_err, 0);
    acc_req = 1'b1;
    step(1);
    chk("R7", dpd_err, 1);
    chk("R7", cke, 0);
    chk("R7", acc_ready, 0);
    step(5);
    acc_req = 1'b0;
    step(1);
    chk("R7", dpd_err, 1);
    chk("R7", cke, 0);

    step(2);
    chk("R11", q.size(), 0);
    finish_run();
  end
endmodule